// File: doc/BRIEF.md
# Register-Commanded MDIO Management Master

This block runs clause-22 management transactions toward an Ethernet PHY from one 32-bit control word. A host writes the word with a read or write request set. The block then clocks a complete frame out on the management clock and data pins. The PHY and register addresses come from the same write, and so does the data for a write. When a read finishes, the returned 16-bit value and a completion flag appear in that same word, so the host polls one location from start to finish.

A third request bit starts a search for an attached PHY. The block reads the identifier register (register 3) at addresses 0, 1, 2 and upward. It stops at the first address whose value is neither 0xFFFF nor 0x0000. The word then reports that address, the identifier value and a completion flag. If no address qualifies, a miss flag is set and the address field defaults to 1.

The control word layout is: bit 31 busy, bit 30 scan miss, bit 29 scan request, bit 28 read done, bit 27 read request, bit 26 write request, bits 25:21 PHY address, bits 20:16 register address, bits 15:0 data. The request bits always read back as 0. Each MDIO bit lasts three phases of `PH_CLKS` system clocks: MDC low, then MDC high, then MDC low.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset, and whenever no transaction is running, the control word holds no busy flag, MDC is low, MDIO output enable is 0 and MDIO out is 1. Directly after reset the whole word reads 0.
- R2: A write to the word with a request bit set launches a frame that carries bits 25:21 as the PHY address and bits 20:16 as the register address. A write frame also carries bits 15:0 as data. These fields read back unchanged after the frame.
- R3: A write frame (bit 26) is 67 bits, all driven: 35 ones, start 0,1, opcode 0,1, 5 PHY address bits and 5 register address bits MSB first, turnaround 1,0, then 16 data bits MSB first.
- R4: A read frame (bit 27) is 66 bits: the same preamble, start and addresses with opcode 1,0. Output enable is released from bit 49 onward (one turnaround bit, then 16 data bits). MDIO in is sampled while MDC is high for bits 50 to 65, and the samples are assembled MSB first.
- R5: When a read completes, bit 28 reads 1, bits 15:0 hold the sampled value and bit 31 is 0. A completed write leaves bit 28 at 0. Bit 28 is never 1 while bit 31 is 1.
- R6: MDC is high for exactly `PH_CLKS` clocks per bit and low for at least 2*`PH_CLKS` clocks between rising edges. MDIO out and output enable change only while MDC is low.
- R7: Bit 31 reads 1 from the cycle after an accepted request until its frame or scan finishes. A busy flag only ever appears after a host write. Writes arriving while busy are ignored: they start no frame and change no field.
- R8: If bits 27 and 26 are both set, a read is performed.
- R9: Bit 29, with bits 27 and 26 clear, starts a scan. The scan reads register 3 at addresses 0 to 31 in ascending order and stops after the first value that is not 0xFFFF and not 0x0000. The word then holds that address in bits 25:21, 3 in bits 20:16, the value in bits 15:0, bit 28 = 1 and bit 30 = 0.
- R10: If no address qualifies, the scan stops after 32 reads with bit 30 = 1, bit 28 = 1 and bits 25:21 = 1.
- R11: A write with none of bits 26, 27 and 29 set starts no frame. It stores bits 25:0 and clears bits 28 and 30. Bits 26, 27 and 29 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read value |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for `mdio_out` |
| mdio_in | input | 1 | Management data returned by the PHY |

## Verification
The assertions assume that the reset input is held for at least one clock. They also assume that the host only learns of completion by polling the busy bit. The stable-while-MDC-high property is stated for the block's own pins only; it depends on nothing the PHY does. The bench PHY model changes `mdio_in` only on MDC falling edges, which keeps the returned data steady through every high phase in which the block samples. The bench issues each new command only after it has seen the busy bit fall, except in the scenario that deliberately writes during a frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    // frame layout, bit index counted from the first preamble bit
    localparam int PREAMBLE_BITS = 35;
    localparam int IDX_START     = PREAMBLE_BITS;
    localparam int IDX_OP        = IDX_START + 2;
    localparam int IDX_PHY       = IDX_OP + 2;
    localparam int IDX_REG       = IDX_PHY + 5;
    localparam int IDX_TA        = IDX_REG + 5;
    localparam int IDX_RDATA     = IDX_TA + 1;
    localparam int IDX_WDATA     = IDX_TA + 2;
    localparam int RD_BITS       = IDX_RDATA + 16;
    localparam int WR_BITS       = IDX_WDATA + 16;
    localparam int IDX_W         = $clog2(WR_BITS);

    localparam logic [4:0]  ID_REG_ADDR    = 5'd3;
    localparam logic [4:0]  FALLBACK_PHY   = 5'd1;
    localparam logic [4:0]  LAST_PHY       = 5'd31;
    localparam logic [15:0] NO_PHY_ONES    = 16'hFFFF;
    localparam logic [15:0] NO_PHY_ZERO    = 16'h0000;

    typedef struct packed {
        logic        busy;
        logic        miss;
        logic        scan;
        logic        done;
        logic        rd;
        logic        wr;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] data;
    } ctl_word_t;

    typedef struct packed {
        logic        rd;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] wdata;
    } frame_req_t;

    typedef enum logic [1:0] {PH_LOW_A, PH_HIGH, PH_LOW_B} bit_phase_e;
    typedef enum logic [1:0] {CTL_IDLE, CTL_FRAME, CTL_SCAN} ctl_state_e;
    typedef enum logic [1:0] {SC_IDLE, SC_ISSUE, SC_WAIT} scan_state_e;

    // value driven on MDIO for bit position idx of a frame
    function automatic logic frame_bit(input logic [IDX_W-1:0] idx, input frame_req_t f);
        int i;
        i = int'(idx);
        if (i < IDX_START)            return 1'b1;
        else if (i == IDX_START)      return 1'b0;
        else if (i == IDX_START + 1)  return 1'b1;
        else if (i == IDX_OP)         return f.rd;
        else if (i == IDX_OP + 1)     return ~f.rd;
        else if (i < IDX_REG)         return f.phy[IDX_REG - 1 - i];
        else if (i < IDX_TA)          return f.regad[IDX_TA - 1 - i];
        else if (i == IDX_TA)         return 1'b1;
        else if (i == IDX_TA + 1)     return 1'b0;
        else if (i < WR_BITS)         return f.wdata[WR_BITS - 1 - i];
        else                          return 1'b1;
    endfunction

endpackage

// File: rtl/mdio_bit_timer.sv
module mdio_bit_timer
    import mdio_pkg::*;
#(
    parameter int PH_CLKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic bit_end
);
    localparam int CW = (PH_CLKS > 1) ? $clog2(PH_CLKS) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(PH_CLKS - 1);

    logic [CW-1:0] cnt;
    bit_phase_e    ph;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            ph  <= PH_LOW_A;
        end else if (cnt == CNT_LAST) begin
            cnt <= '0;
            case (ph)
                PH_LOW_A: ph <= PH_HIGH;
                PH_HIGH:  ph <= PH_LOW_B;
                default:  ph <= PH_LOW_A;
            endcase
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign mdc       = (ph == PH_HIGH);
    assign rise_tick = run && (ph == PH_HIGH) && (cnt == '0);
    assign bit_end   = run && (ph == PH_LOW_B) && (cnt == CNT_LAST);

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
#(
    parameter int PH_CLKS = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  frame_req_t  req,
    input  logic        mdio_in,
    output logic        idle,
    output logic        done,
    output logic [15:0] rdata,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe
);
    localparam logic [IDX_W-1:0] RD_LAST = IDX_W'(RD_BITS - 1);
    localparam logic [IDX_W-1:0] WR_LAST = IDX_W'(WR_BITS - 1);
    localparam logic [IDX_W-1:0] TA_POS  = IDX_W'(IDX_TA);
    localparam logic [IDX_W-1:0] RD_POS  = IDX_W'(IDX_RDATA);

    logic             active;
    frame_req_t       cur;
    logic [IDX_W-1:0] idx;
    logic [15:0]      shift;
    logic             rise_tick;
    logic             bit_end;
    logic             last_bit;

    mdio_bit_timer #(.PH_CLKS(PH_CLKS)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (active),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .bit_end   (bit_end)
    );

    assign last_bit = (idx == (cur.rd ? RD_LAST : WR_LAST));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cur    <= '0;
            idx    <= '0;
            shift  <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    cur    <= req;
                    idx    <= '0;
                    shift  <= '0;
                end
            end else begin
                if (rise_tick && cur.rd && (idx >= RD_POS))
                    shift <= {shift[14:0], mdio_in};
                if (bit_end) begin
                    if (last_bit) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            end
        end
    end

    assign idle     = !active;
    assign rdata    = shift;
    assign mdio_oe  = active && !(cur.rd && (idx >= TA_POS));
    assign mdio_out = active ? frame_bit(idx, cur) : 1'b1;

endmodule

// File: rtl/mdio_phy_scan.sv
module mdio_phy_scan
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        go,
    input  logic        eng_idle,
    input  logic        eng_done,
    input  logic [15:0] eng_rdata,
    output logic        req_start,
    output logic [4:0]  req_phy,
    output logic        fin,
    output logic        found,
    output logic [4:0]  found_phy,
    output logic [15:0] id_val
);
    scan_state_e st;
    logic [4:0]  cur;
    logic        hit;

    assign hit = (eng_rdata != NO_PHY_ONES) && (eng_rdata != NO_PHY_ZERO);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SC_IDLE;
            cur       <= '0;
            fin       <= 1'b0;
            found     <= 1'b0;
            found_phy <= '0;
            id_val    <= '0;
        end else begin
            fin <= 1'b0;
            case (st)
                SC_IDLE: if (go) begin
                    cur <= '0;
                    st  <= SC_ISSUE;
                end
                SC_ISSUE: if (eng_idle) st <= SC_WAIT;
                SC_WAIT: if (eng_done) begin
                    id_val <= eng_rdata;
                    if (hit) begin
                        fin       <= 1'b1;
                        found     <= 1'b1;
                        found_phy <= cur;
                        st        <= SC_IDLE;
                    end else if (cur == LAST_PHY) begin
                        fin       <= 1'b1;
                        found     <= 1'b0;
                        found_phy <= FALLBACK_PHY;
                        st        <= SC_IDLE;
                    end else begin
                        cur <= cur + 1'b1;
                        st  <= SC_ISSUE;
                    end
                end
                default: st <= SC_IDLE;
            endcase
        end
    end

    assign req_start = (st == SC_ISSUE) && eng_idle;
    assign req_phy   = cur;

endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
    import mdio_pkg::*;
#(
    parameter int PH_CLKS = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    ctl_word_t   wcmd;
    ctl_word_t   rword;
    ctl_state_e  st;
    logic        last_rd;
    logic        miss_q;
    logic        done_q;
    logic [4:0]  phy_q;
    logic [4:0]  regad_q;
    logic [15:0] data_q;

    logic        host_ok;
    logic        host_frame;
    logic        host_scan;
    logic        eng_start;
    frame_req_t  eng_req;
    logic        eng_idle;
    logic        eng_done;
    logic [15:0] eng_rdata;

    logic        scan_start;
    logic [4:0]  scan_phy;
    logic        scan_fin;
    logic        scan_found;
    logic [4:0]  scan_found_phy;
    logic [15:0] scan_id;

    assign wcmd       = ctl_word_t'(reg_wdata);
    assign host_ok    = reg_wr && (st == CTL_IDLE);
    assign host_frame = host_ok && (wcmd.rd || wcmd.wr);
    assign host_scan  = host_ok && !wcmd.rd && !wcmd.wr && wcmd.scan;
    assign eng_start  = host_frame || scan_start;

    always_comb begin
        if (host_frame) begin
            eng_req.rd    = wcmd.rd;
            eng_req.phy   = wcmd.phy;
            eng_req.regad = wcmd.regad;
            eng_req.wdata = wcmd.data;
        end else begin
            eng_req.rd    = 1'b1;
            eng_req.phy   = scan_phy;
            eng_req.regad = ID_REG_ADDR;
            eng_req.wdata = '0;
        end
    end

    mdio_frame_engine #(.PH_CLKS(PH_CLKS)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .start    (eng_start),
        .req      (eng_req),
        .mdio_in  (mdio_in),
        .idle     (eng_idle),
        .done     (eng_done),
        .rdata    (eng_rdata),
        .mdc      (mdc),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe)
    );

    mdio_phy_scan u_scan (
        .clk       (clk),
        .rst       (rst),
        .go        (host_scan),
        .eng_idle  (eng_idle),
        .eng_done  (eng_done),
        .eng_rdata (eng_rdata),
        .req_start (scan_start),
        .req_phy   (scan_phy),
        .fin       (scan_fin),
        .found     (scan_found),
        .found_phy (scan_found_phy),
        .id_val    (scan_id)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= CTL_IDLE;
            last_rd <= 1'b0;
            miss_q  <= 1'b0;
            done_q  <= 1'b0;
            phy_q   <= '0;
            regad_q <= '0;
            data_q  <= '0;
        end else begin
            case (st)
                CTL_IDLE: if (host_ok) begin
                    phy_q   <= wcmd.phy;
                    regad_q <= wcmd.regad;
                    data_q  <= wcmd.data;
                    done_q  <= 1'b0;
                    miss_q  <= 1'b0;
                    last_rd <= wcmd.rd;
                    if (host_frame)     st <= CTL_FRAME;
                    else if (host_scan) st <= CTL_SCAN;
                end
                CTL_FRAME: if (eng_done) begin
                    st <= CTL_IDLE;
                    if (last_rd) begin
                        data_q <= eng_rdata;
                        done_q <= 1'b1;
                    end
                end
                CTL_SCAN: if (scan_fin) begin
                    st      <= CTL_IDLE;
                    phy_q   <= scan_found ? scan_found_phy : FALLBACK_PHY;
                    regad_q <= ID_REG_ADDR;
                    data_q  <= scan_id;
                    done_q  <= 1'b1;
                    miss_q  <= !scan_found;
                end
                default: st <= CTL_IDLE;
            endcase
        end
    end

    always_comb begin
        rword.busy  = (st != CTL_IDLE);
        rword.miss  = miss_q;
        rword.scan  = 1'b0;
        rword.done  = done_q;
        rword.rd    = 1'b0;
        rword.wr    = 1'b0;
        rword.phy   = phy_q;
        rword.regad = regad_q;
        rword.data  = data_q;
    end

    assign reg_rdata = rword;

endmodule

// File: rtl/mdio_cmd_master_chk.sv
module mdio_cmd_master_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [31:0] reg_rdata,
    input logic        mdc,
    input logic        mdio_out,
    input logic        mdio_oe
);
    AST_IDLE_PINS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !reg_rdata[31] |-> (!mdc && !mdio_oe && mdio_out)); // R1

    AST_MDIO_STEADY_WHILE_MDC_HIGH: assert property (@(posedge clk) disable iff (rst)
        mdc |-> ($stable(mdio_out) && $stable(mdio_oe))); // R6

    AST_BUSY_ONLY_AFTER_HOST_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(reg_rdata[31]) |-> $past(reg_wr)); // R7

    AST_DONE_EXCLUDES_BUSY: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[28] |-> !reg_rdata[31]); // R5

    AST_MISS_GIVES_DEFAULT_ADDR: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[30] |-> (reg_rdata[25:21] == 5'd1 && reg_rdata[28])); // R10

endmodule

bind mdio_cmd_master mdio_cmd_master_chk i_chk (.*);

// File: tb/test_mdio_cmd_master.sv
module test_mdio_cmd_master;

    localparam int PH = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc;
    logic        mdio_out;
    logic        mdio_oe;
    logic        mdio_in = 1'b1;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    mdio_cmd_master #(.PH_CLKS(PH)) i_mdio_cmd_master (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mdc(mdc), .mdio_out(mdio_out),
        .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    // ---------------- PHY model ----------------
    logic [15:0] phy_val [32];
    int          nb = 0;
    bit          m_rd = 0;
    logic [4:0]  m_phy = '0;
    logic [4:0]  m_reg = '0;
    logic [15:0] m_resp = '0;
    logic [66:0] cap_o = '0, cap_oe = '0;
    logic [66:0] last_o = '0, last_oe = '0;
    int          last_len = 0;
    int          frames = 0;

    function automatic logic [15:0] resp(input logic [4:0] a, input logic [4:0] r);
        if (r == 5'd3) return phy_val[a];
        if (phy_val[a] == 16'hFFFF) return 16'hFFFF;
        return phy_val[a] ^ {11'd0, r};
    endfunction

    always @(posedge mdc) begin
        cap_o[66-nb]  = mdio_out;
        cap_oe[66-nb] = mdio_oe;
        if (nb == 38) m_rd = cap_o[66-37] && !cap_o[66-38];
        if (nb == 43) m_phy = cap_o[66-39 -: 5];
        if (nb == 48) begin
            m_reg  = cap_o[66-44 -: 5];
            m_resp = resp(m_phy, m_reg);
        end
        nb = nb + 1;
        if (nb == (m_rd ? 66 : 67)) begin
            last_o   = cap_o;
            last_oe  = cap_oe;
            last_len = nb;
            frames   = frames + 1;
            nb       = 0;
            cap_o    = '0;
            cap_oe   = '0;
        end
    end

    always @(negedge mdc) begin
        if (m_rd && nb >= 50 && nb <= 65) mdio_in = m_resp[15-(nb-50)];
        else mdio_in = 1'b1;
    end

    // ---------------- MDC timing monitor (R6) ----------------
    int  hi_run = 0, lo_run = 0, mdc_bad = 0;
    bit  prev_mdc = 0, seen_rise = 0;
    logic prev_out = 1'b1, prev_oe = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (mdc && !prev_mdc) begin
                if (seen_rise && lo_run < 2*PH) mdc_bad++;
                seen_rise = 1;
                hi_run = 1;
            end else if (!mdc && prev_mdc) begin
                if (hi_run != PH) mdc_bad++;
                lo_run = 1;
            end else if (mdc) begin
                hi_run++;
                if (mdio_out !== prev_out || mdio_oe !== prev_oe) mdc_bad++;
            end else begin
                lo_run++;
            end
        end
        prev_mdc = mdc;
        prev_out = mdio_out;
        prev_oe  = mdio_oe;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag, input logic [66:0] act, input logic [66:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [31:0] w);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_wdata = w;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic wait_idle(input string tag);
        int cyc;
        cyc = 0;
        while (reg_rdata[31] && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        chk(!reg_rdata[31], {tag, " completion within bound"}, 67'(cyc), 67'd20000);
    endtask

    function automatic logic [31:0] cmd(input bit scan, input bit rd, input bit wr,
                                        input logic [4:0] p, input logic [4:0] r,
                                        input logic [15:0] d);
        return {2'b00, scan, 1'b0, rd, wr, p, r, d};
    endfunction

    function automatic logic [66:0] wr_frame(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
        return {{35{1'b1}}, 2'b01, 2'b01, p, r, 2'b10, d};
    endfunction

    function automatic logic [48:0] rd_head(input logic [4:0] p, input logic [4:0] r);
        return {{35{1'b1}}, 2'b01, 2'b10, p, r};
    endfunction

    task automatic clear_phys;
        for (int a = 0; a < 32; a++) phy_val[a] = 16'hFFFF;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        chk(reg_rdata == 32'h0, "R1 control word after reset", 67'(reg_rdata), 67'h0);
        chk(!mdc && !mdio_oe && mdio_out, "R1 idle pins after reset",
            67'({mdc, mdio_oe, mdio_out}), 67'b001);
    endtask

    task automatic t_write;
        int f0;
        f0 = frames;
        host_write(cmd(0, 0, 1, 5'h13, 5'h0A, 16'hA5C3));
        chk(reg_rdata[31], "R7 busy after accepted write", 67'(reg_rdata[31]), 67'd1);
        wait_idle("R3 write");
        chk(frames == f0 + 1 && last_len == 67, "R3 one 67-bit write frame", 67'(last_len), 67'd67);
        chk(last_o == wr_frame(5'h13, 5'h0A, 16'hA5C3), "R3 R2 write frame bits",
            last_o, wr_frame(5'h13, 5'h0A, 16'hA5C3));
        chk(last_oe == {67{1'b1}}, "R3 enable held for whole write", last_oe, {67{1'b1}});
        chk(reg_rdata == cmd(0, 0, 0, 5'h13, 5'h0A, 16'hA5C3), "R5 R2 word after write",
            67'(reg_rdata), 67'(cmd(0, 0, 0, 5'h13, 5'h0A, 16'hA5C3)));
        chk(mdc_bad == 0, "R6 mdc shape during write", 67'(mdc_bad), 67'd0);
    endtask

    task automatic t_read(input logic [4:0] p, input logic [4:0] r, input bit both, input string tag);
        int f0;
        logic [15:0] e;
        f0 = frames;
        e  = resp(p, r);
        host_write(cmd(0, 1, both, p, r, 16'h5555));
        wait_idle(tag);
        chk(frames == f0 + 1 && last_len == 66, {tag, " one 66-bit read frame"}, 67'(last_len), 67'd66);
        chk(last_o[66:18] == rd_head(p, r), {tag, " read header bits"}, 67'(last_o[66:18]), 67'(rd_head(p, r)));
        chk(last_oe[66:18] == {49{1'b1}} && last_oe[17:1] == '0, {tag, " R4 enable released from bit 49"},
            last_oe, {{49{1'b1}}, 18'd0});
        chk(reg_rdata == {3'b000, 1'b1, 2'b00, p, r, e}, {tag, " R5 done flag and data"},
            67'(reg_rdata), 67'({3'b000, 1'b1, 2'b00, p, r, e}));
    endtask

    task automatic t_busy_ignore;
        int f0;
        logic [15:0] e;
        f0 = frames;
        e  = resp(5'd6, 5'd3);
        host_write(cmd(0, 1, 0, 5'd6, 5'd3, 16'h0));
        repeat (20) @(negedge clk);
        chk(reg_rdata[31], "R7 busy mid-frame", 67'(reg_rdata[31]), 67'd1);
        host_write(cmd(0, 0, 1, 5'd9, 5'd7, 16'hBEEF));
        host_write(cmd(1, 0, 0, 5'd2, 5'd2, 16'h1111));
        wait_idle("R7 ignore");
        repeat (40) @(negedge clk);
        chk(frames == f0 + 1 && !reg_rdata[31], "R7 writes during busy start nothing",
            67'(frames - f0), 67'd1);
        chk(reg_rdata == {3'b000, 1'b1, 2'b00, 5'd6, 5'd3, e}, "R7 fields untouched by ignored writes",
            67'(reg_rdata), 67'({3'b000, 1'b1, 2'b00, 5'd6, 5'd3, e}));
    endtask

    task automatic t_plain_store;
        int f0;
        f0 = frames;
        host_write(cmd(0, 0, 0, 5'd17, 5'd4, 16'h3C3C));
        chk(!reg_rdata[31], "R11 no busy for plain store", 67'(reg_rdata[31]), 67'd0);
        repeat (30) @(negedge clk);
        chk(frames == f0 && nb == 0, "R11 no frame for plain store", 67'(frames - f0), 67'd0);
        chk(reg_rdata == cmd(0, 0, 0, 5'd17, 5'd4, 16'h3C3C), "R11 fields stored, flags clear",
            67'(reg_rdata), 67'(cmd(0, 0, 0, 5'd17, 5'd4, 16'h3C3C)));
    endtask

    task automatic t_scan(input int want, input string tag);
        int f0;
        logic [31:0] e;
        f0 = frames;
        host_write(cmd(1, 0, 0, 5'd0, 5'd0, 16'h0));
        chk(reg_rdata[31] && !reg_rdata[29], {tag, " R11 busy with scan bit reading 0"},
            67'(reg_rdata[31:29]), 67'b100);
        wait_idle(tag);
        if (want < 0) begin
            e = {1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 5'd1, 5'd3, 16'hFFFF};
            chk(frames == f0 + 32, {tag, " R10 32 reads made"}, 67'(frames - f0), 67'd32);
        end else begin
            e = {1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 5'(want), 5'd3, phy_val[want]};
            chk(frames == f0 + want + 1, {tag, " R9 stops at first hit"}, 67'(frames - f0), 67'(want + 1));
        end
        chk(reg_rdata == e, {tag, " scan result word"}, 67'(reg_rdata), 67'(e));
        chk(last_o[66:18] == rd_head(want < 0 ? 5'd31 : 5'(want), 5'd3),
            {tag, " R9 last scan frame addresses register 3"},
            67'(last_o[66:18]), 67'(rd_head(want < 0 ? 5'd31 : 5'(want), 5'd3)));
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    // ---------------- main ----------------
    initial begin
        clear_phys();
        phy_val[5] = 16'h1234;
        phy_val[6] = 16'h0141;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write();
        t_read(5'd5, 5'd3, 0, "R4 read id");
        t_read(5'd5, 5'd2, 0, "R4 read other reg");
        t_read(5'd6, 5'd3, 1, "R8 both requests");
        t_busy_ignore();
        t_plain_store();

        clear_phys();
        t_scan(-1, "R10 empty bus");
        clear_phys();
        phy_val[0] = 16'h0000;
        phy_val[6] = 16'h2000;
        phy_val[9] = 16'h0022;
        t_scan(6, "R9 skips zero and ones");
        clear_phys();
        phy_val[0] = 16'h8001;
        t_scan(0, "R9 address 0");
        clear_phys();
        phy_val[31] = 16'h7FFE;
        t_scan(31, "R9 address 31");

        chk(mdc_bad == 0, "R6 mdc shape whole run", 67'(mdc_bad), 67'd0);
        chk(!mdc && !mdio_oe && mdio_out, "R1 idle pins at end",
            67'({mdc, mdio_oe, mdio_out}), 67'b001);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule